// File: doc/BRIEF.md
# SAR Converter Conversion and Readout Sequencer

This block sits on the host side of one or more 16-bit successive-approximation converters. Each converter times its own conversion with an internal oscillator and returns its result over a serial link. When a sample tick is accepted, the sequencer raises the convert line for a minimum pulse width. It then waits until the converter's busy flag drops, or until a worst-case conversion deadline passes. After that it enables the serial output, toggles the shift clock, and assembles each device's result into a parallel two's-complement word with a one-cycle valid strobe.

Several converters can be chained so that each one's serial output feeds the next one's serial input. One conversion then yields one burst holding a word from every device. The device wired to the host arrives first. Every analog-side timing minimum is given in picoseconds alongside the system clock period. The sequencer rounds each one up to a whole number of system clock cycles, so no minimum is ever undercut. The data read after a conversion always belongs to that same conversion.

Top module: `sar_readout_ctrl`

## Requirements
- R1: An accepted sample tick drives `adc_cnv` high for exactly CNVH_CYC system cycles (ceiling of 20 ns over the clock period; 2 at defaults).
- R2: Two rising edges of `adc_cnv` are never closer than CYC_CYC cycles (ceiling of 2 µs; 200 at defaults). With the tick held high, they are exactly CYC_CYC cycles apart.
- R3: `adc_sck` stays low while `adc_busy` is high and the deadline has not been reached. It also stays low for at least QUIET_CYC cycles after the rising edge of `adc_cnv`.
- R4: If `adc_busy` is still high in the cycle where CONV_CYC cycles (ceiling of 1.5 µs; 150 at defaults) have elapsed since the convert edge, `timeout_err` is set and stays set until reset. The read is still carried out. If busy falls in exactly that cycle, no error is raised.
- R5: `adc_rd_n` (active low) is low only during a readout, and `adc_sck` rises only while it is low. Each readout has exactly 16*CHAIN_N-1 rising shift-clock edges, and no rise follows the last captured bit.
- R6: The first bit is sampled before the first shift-clock rise. It is the MSB (bit 15) of the word; each later rise yields the next lower bit.
- R7: One readout emits CHAIN_N words. The first word comes from the device attached to `adc_sdo`, the last from the device furthest away. `word_last` is high only with the final word.
- R8: The words emitted after a conversion are the results of that conversion, not of an earlier one.
- R9: A tick that does not start a conversion, because a conversion or read is in progress or the spacing of R2 has not elapsed, adds one to `overrun_cnt`. The counter saturates at all ones, and no convert pulse follows the tick.
- R10: After reset: `adc_cnv`=0, `adc_sck`=0, `adc_rd_n`=1, `word_valid`=0, `timeout_err`=0, `overrun_cnt`=0.
- R11: Words pass through unchanged as two's complement, including 0x0000, 0xFFFF, 0x8000 and 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Request to start one conversion |
| adc_busy | input | 1 | Converter busy flag, high while converting |
| adc_sdo | input | 1 | Serial result bit from the nearest device |
| adc_cnv | output | 1 | Convert strobe to all devices |
| adc_sck | output | 1 | Shift clock to all devices |
| adc_rd_n | output | 1 | Serial output enable, active low |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | WORD_W | Assembled two's-complement result |
| word_last | output | 1 | Marks the final word of a burst |
| timeout_err | output | 1 | Sticky flag: busy exceeded the deadline |
| overrun_cnt | output | OVR_W | Saturating count of rejected ticks |

## Verification
Two events can land on the same edge: the busy flag dropping, and the conversion deadline expiring. When both happen together, the busy fall must win, and no error may be reported. The bench sets the modelled busy length to 148 cycles, which makes busy drop in exactly the deadline cycle, and checks that `timeout_err` stays clear. It then uses 149 cycles, which misses the deadline by one, and checks that the flag sets while both readouts still deliver the correct words.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT,
    ST_EN,
    ST_LO,
    ST_HI
  } sarc_state_e;

  // Round a time up to whole clock cycles so a minimum is never undercut.
  function automatic int cyc_ceil(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sarc_pace.sv
// Elapsed cycles since the last convert edge, saturating at LIM.
module sarc_pace #(
  parameter int LIM = 200,
  parameter int SW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [SW-1:0] since
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since <= SW'(LIM);
    else if (start)              since <= '0;
    else if (since != SW'(LIM))  since <= since + 1'b1;
  end
endmodule

// File: rtl/sarc_sat_cnt.sv
module sarc_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             q <= '0;
    else if (inc && q != '1) q <= q + 1'b1;
  end
endmodule

// File: rtl/sarc_shift.sv
// Collects serial bits MSB first and emits one word per device.
module sarc_shift #(
  parameter int WORD_W  = 16,
  parameter int CHAIN_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap,
  input  logic              sdo,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_last
);
  localparam int WB = $clog2(WORD_W);
  localparam int CB = (CHAIN_N > 1) ? $clog2(CHAIN_N) : 1;

  logic [WORD_W-1:0] sh;
  logic [WB-1:0]     bit_idx;
  logic [CB-1:0]     word_idx;
  logic [WORD_W-1:0] sh_next;
  logic              word_done;

  assign sh_next   = {sh[WORD_W-2:0], sdo};
  assign word_done = cap && (bit_idx == WB'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; bit_idx <= '0; word_idx <= '0;
      word_valid <= 1'b0; word_data <= '0; word_last <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      word_last  <= 1'b0;
      if (clr) begin
        bit_idx  <= '0;
        word_idx <= '0;
      end else if (cap) begin
        sh <= sh_next;
        if (word_done) begin
          bit_idx    <= '0;
          word_idx   <= word_idx + 1'b1;
          word_data  <= sh_next;
          word_valid <= 1'b1;
          word_last  <= (word_idx == CB'(CHAIN_N - 1));
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sarc_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int CHAIN_N      = 2,
  parameter int OVR_W        = 8,
  parameter int CLK_PS       = 10000,
  parameter int CNVH_PS      = 20000,
  parameter int CONV_PS      = 1500000,
  parameter int CYC_PS       = 2000000,
  parameter int QUIET_PS     = 20000,
  parameter int EN_PS        = 16000,
  parameter int SCK_HALF_PS  = 4000,
  parameter int SCK_PER_PS   = 10000,
  parameter int CHAIN_PER_PS = 13500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              adc_busy,
  input  logic              adc_sdo,
  output logic              adc_cnv,
  output logic              adc_sck,
  output logic              adc_rd_n,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_last,
  output logic              timeout_err,
  output logic [OVR_W-1:0]  overrun_cnt
);
  localparam int CNVH_CYC   = max2(1, cyc_ceil(CNVH_PS, CLK_PS));
  localparam int CONV_CYC   = max2(1, cyc_ceil(CONV_PS, CLK_PS));
  localparam int CYC_CYC    = max2(1, cyc_ceil(CYC_PS, CLK_PS));
  localparam int QUIET_CYC  = max2(1, cyc_ceil(QUIET_PS, CLK_PS));
  localparam int EN_CYC     = max2(1, cyc_ceil(EN_PS, CLK_PS));
  localparam int PER_PS     = (CHAIN_N > 1) ? CHAIN_PER_PS : SCK_PER_PS;
  localparam int HALF_CYC   = max2(max2(1, cyc_ceil(SCK_HALF_PS, CLK_PS)),
                                   cyc_ceil(PER_PS, 2 * CLK_PS));
  localparam int LIM        = max2(CYC_CYC, CONV_CYC);
  localparam int SW         = $clog2(LIM + 1);
  localparam int TOTAL_BITS = WORD_W * CHAIN_N;
  localparam int BIT_W      = $clog2(TOTAL_BITS);
  localparam int PH_W       = $clog2(max2(EN_CYC, HALF_CYC) + 1);

  sarc_state_e       state, nxt;
  logic [SW-1:0]     since_cnv;
  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  bit_cnt;

  // Named internal events, also seen by the checker.
  logic start_ok, cnvh_done, quiet_ok, to_hit, phase_end, last_bit, bit_cap, rejected;

  assign start_ok  = (state == ST_IDLE) && (since_cnv >= SW'(CYC_CYC - 1)) && sample_tick;
  assign cnvh_done = since_cnv >= SW'(CNVH_CYC - 1);
  assign quiet_ok  = since_cnv >= SW'(QUIET_CYC - 1);
  assign to_hit    = since_cnv >= SW'(CONV_CYC - 1);
  assign phase_end = (state == ST_EN) ? (ph == PH_W'(EN_CYC - 1)) : (ph == PH_W'(HALF_CYC - 1));
  assign last_bit  = bit_cnt == BIT_W'(TOTAL_BITS - 1);
  assign bit_cap   = (state == ST_LO) && phase_end;
  assign rejected  = sample_tick && !start_ok;

  sarc_pace #(.LIM(LIM), .SW(SW)) u_pace (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .since(since_cnv)
  );

  sarc_sat_cnt #(.W(OVR_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .inc(rejected), .q(overrun_cnt)
  );

  sarc_shift #(.WORD_W(WORD_W), .CHAIN_N(CHAIN_N)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .cap(bit_cap), .sdo(adc_sdo),
    .word_valid(word_valid), .word_data(word_data), .word_last(word_last)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start_ok) nxt = ST_CNV;
      ST_CNV:  if (cnvh_done) nxt = ST_WAIT;
      ST_WAIT: if ((!adc_busy && quiet_ok) || to_hit) nxt = ST_EN;
      ST_EN:   if (phase_end) nxt = ST_LO;
      ST_LO:   if (phase_end) nxt = last_bit ? ST_IDLE : ST_HI;
      ST_HI:   if (phase_end) nxt = ST_LO;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ph          <= '0;
      bit_cnt     <= '0;
      timeout_err <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state || !(state inside {ST_EN, ST_LO, ST_HI})) ph <= '0;
      else                                                        ph <= ph + 1'b1;
      if (start_ok)                          bit_cnt <= '0;
      else if (state == ST_HI && phase_end)  bit_cnt <= bit_cnt + 1'b1;
      if (state == ST_WAIT && to_hit && adc_busy) timeout_err <= 1'b1;
    end
  end

  assign adc_cnv  = (state == ST_CNV);
  assign adc_sck  = (state == ST_HI);
  assign adc_rd_n = !(state inside {ST_EN, ST_LO, ST_HI});

endmodule

// File: rtl/sarc_checker.sv
module sarc_checker #(
  parameter int CNVH_CYC  = 2,
  parameter int CYC_CYC   = 200,
  parameter int QUIET_CYC = 2,
  parameter int SW        = 8,
  parameter int OVR_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_tick,
  input logic             start_ok,
  input logic [SW-1:0]    since_cnv,
  input logic             adc_cnv,
  input logic             adc_sck,
  input logic             adc_rd_n,
  input logic             timeout_err,
  input logic             word_valid,
  input logic             word_last,
  input logic [OVR_W-1:0] overrun_cnt
);
  // R1
  cnv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_cnv && since_cnv < SW'(CNVH_CYC - 1)) |=> adc_cnv);
  // R1
  cnv_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cnv) |-> since_cnv == '0);
  // R2
  cnv_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cnv) |-> $past(since_cnv) >= SW'(CYC_CYC - 1));
  // R3
  sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sck |-> since_cnv >= SW'(QUIET_CYC));
  // R5
  sck_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sck |-> !adc_rd_n);
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_last |-> word_valid);
  // R9
  overrun_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !start_ok && overrun_cnt != '1) |=> overrun_cnt == $past(overrun_cnt) + OVR_W'(1));
  // R9
  overrun_nocnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !start_ok && !adc_cnv) |=> !adc_cnv);
endmodule

bind sar_readout_ctrl sarc_checker #(
  .CNVH_CYC(CNVH_CYC), .CYC_CYC(CYC_CYC), .QUIET_CYC(QUIET_CYC), .SW(SW), .OVR_W(OVR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .start_ok(start_ok),
  .since_cnv(since_cnv), .adc_cnv(adc_cnv), .adc_sck(adc_sck), .adc_rd_n(adc_rd_n),
  .timeout_err(timeout_err), .word_valid(word_valid), .word_last(word_last),
  .overrun_cnt(overrun_cnt)
);

// File: tb/sar_readout_ctrl_test.sv
module sar_readout_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int N    = 2;
  localparam int BITS = W * N;

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0;
  logic adc_busy, adc_sdo, adc_cnv, adc_sck, adc_rd_n;
  logic word_valid, word_last, timeout_err;
  logic [W-1:0] word_data;
  logic [7:0]   overrun_cnt;

  int n_checks = 0, n_fail = 0, cyc = 0;

  sar_readout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .adc_busy(adc_busy),
    .adc_sdo(adc_sdo), .adc_cnv(adc_cnv), .adc_sck(adc_sck), .adc_rd_n(adc_rd_n),
    .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
    .timeout_err(timeout_err), .overrun_cnt(overrun_cnt)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Converter chain model: results latched at the convert edge, shifted on sck rise.
  logic [W-1:0]   near_w = '0, far_w = '0;
  int             busy_len = 10, busy_cnt = 0;
  logic [BITS-1:0] chain = '0;
  logic           cnv_q = 1'b0, sck_q = 1'b0;

  always @(posedge clk) begin
    cnv_q <= adc_cnv;
    sck_q <= adc_sck;
    if (adc_cnv && !cnv_q) begin
      busy_cnt <= busy_len;
      chain    <= {near_w, far_w};
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (adc_sck && !sck_q) chain <= {chain[BITS-2:0], 1'b0};
    end
  end
  assign adc_busy = (busy_cnt != 0);
  assign adc_sdo  = adc_rd_n ? 1'b1 : chain[BITS-1];

  // Monitors, sampled away from the active edge.
  logic [W-1:0] words [8];
  logic         lasts [8];
  int nw = 0, n_cnv = 0, n_sck = 0, bad_sck = 0, busy_sck = 0;
  int hi_len = 0, last_hi = 0, rise_a = 0, rise_b = 0;
  logic pc = 1'b0, ps = 1'b0;

  always @(negedge clk) begin
    if (word_valid && nw < 8) begin
      words[nw] = word_data; lasts[nw] = word_last; nw++;
    end
    if (adc_cnv && !pc) begin n_cnv++; rise_a = rise_b; rise_b = cyc; hi_len = 0; end
    if (adc_cnv) hi_len++;
    if (!adc_cnv && pc) last_hi = hi_len;
    if (adc_sck && !ps) begin
      n_sck++;
      if (adc_rd_n) bad_sck++;
      if (adc_busy) busy_sck++;
    end
    pc = adc_cnv;
    ps = adc_sck;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nw = 0; n_cnv = 0; n_sck = 0; bad_sck = 0; busy_sck = 0;
  endtask

  task automatic run_conv(input logic [W-1:0] a, input logic [W-1:0] b, input int bl);
    near_w = a; far_w = b; busy_len = bl;
    clear_mon();
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    repeat (260) @(negedge clk);
  endtask

  task automatic check_words(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    chk(nw == 2, req, nw, 2);
    chk(words[0] == a, req, words[0], a);
    chk(words[1] == b, req, words[1], b);
  endtask

  task automatic t_reset();
    // R10
    chk(!adc_cnv && !adc_sck && adc_rd_n, "R10 idle lines", {adc_cnv, adc_sck, adc_rd_n}, 3'b001);
    chk(!word_valid && !timeout_err, "R10 flags", {word_valid, timeout_err}, 0);
    chk(overrun_cnt == 0, "R10 overrun", overrun_cnt, 0);
  endtask

  task automatic t_basic();
    run_conv(16'h8000, 16'h7FFF, 60);
    check_words(16'h8000, 16'h7FFF, "R11 extreme codes");
    chk(!lasts[0] && lasts[1], "R7 last flag", {lasts[0], lasts[1]}, 2'b01);
    chk(last_hi == 2, "R1 cnv width", last_hi, 2);
    chk(n_cnv == 1, "R1 one pulse", n_cnv, 1);
    chk(busy_sck == 0, "R3 no sck while busy", busy_sck, 0);
    chk(bad_sck == 0, "R5 sck only when enabled", bad_sck, 0);
    chk(n_sck == BITS - 1, "R5 sck edge count", n_sck, BITS - 1);
    chk(adc_rd_n, "R5 disabled after read", adc_rd_n, 1);
    chk(!timeout_err, "R4 no error", timeout_err, 0);
  endtask

  task automatic t_codes();
    run_conv(16'h0000, 16'hFFFF, 40);
    check_words(16'h0000, 16'hFFFF, "R11 zero straddle");
    run_conv(16'hA5C3, 16'h3C5A, 25);
    check_words(16'hA5C3, 16'h3C5A, "R6 MSB first / R7 order");
  endtask

  task automatic t_deadline();
    run_conv(16'h1357, 16'h9BDF, 148);
    chk(!timeout_err, "R4 busy falls on deadline", timeout_err, 0);
    check_words(16'h1357, 16'h9BDF, "R8 data at deadline");
  endtask

  task automatic t_timeout();
    run_conv(16'hCAFE, 16'h0F0F, 149);
    chk(timeout_err, "R4 timeout sets error", timeout_err, 1);
    check_words(16'hCAFE, 16'h0F0F, "R4 read after timeout");
    run_conv(16'h2468, 16'hFEDC, 30);
    chk(timeout_err, "R4 error sticky", timeout_err, 1);
    check_words(16'h2468, 16'hFEDC, "R8 fresh conversion data");
  endtask

  task automatic t_overrun();
    logic [7:0] o0;
    o0 = overrun_cnt;
    near_w = 16'h1234; far_w = 16'h5678; busy_len = 60;
    clear_mon();
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    repeat (98) @(negedge clk);
    sample_tick = 1'b1;                 // during readout
    @(negedge clk) sample_tick = 1'b0;
    repeat (68) @(negedge clk);
    sample_tick = 1'b1;                 // idle, spacing not yet elapsed
    @(negedge clk) sample_tick = 1'b0;
    repeat (120) @(negedge clk);
    chk(overrun_cnt == o0 + 8'd2, "R9 overrun count", overrun_cnt, o0 + 8'd2);
    chk(n_cnv == 1, "R9 no extra conversion", n_cnv, 1);
    check_words(16'h1234, 16'h5678, "R9 read unaffected");
  endtask

  task automatic t_pace();
    busy_len = 20;
    clear_mon();
    @(negedge clk) sample_tick = 1'b1;
    repeat (450) @(negedge clk);
    sample_tick = 1'b0;
    repeat (5) @(negedge clk);
    chk(n_cnv == 3, "R2 conversions while held", n_cnv, 3);
    chk(rise_b - rise_a == 200, "R2 exact spacing", rise_b - rise_a, 200);
    chk(overrun_cnt == 8'hFF, "R9 saturation", overrun_cnt, 8'hFF);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_codes();
    t_deadline();
    t_timeout();
    t_overrun();
    t_pace();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule